// File: doc/BRIEF.md
# Flash Chip-Select Segment Window Decoder

This block keeps one window register per flash chip select. Each register places that chip's address window inside a shared flash aperture, in coarse units of 8 MB. An incoming memory-mapped address is turned into a chip-select index and an offset within the chosen window, or into a miss. Software reaches the registers through a plain index/data write port and a combinational read port.

Each register write is validated before it lands. On chip 0 the start field cannot be moved away from the aperture base. A window that falls outside the aperture is refused. A misaligned window or one that overlaps another chip's window is reported, but the write is still applied. Three one-cycle flags report these outcomes. The SPI transfer and bus arbitration sit outside this block.

Top module: `flash_seg_decoder`

## Requirements
- R1: A register reads as {end[31:24], start[23:16], 16'h0}, where each field is an address in 8 MB units (address bits 30:23). A read at an index of NUM_CS or above returns zero.
- R2: After reset, register i holds DEF_END[8i+7:8i] and DEF_START[8i+7:8i]. With the default parameters these are 40–48, 48–4C, 4C–50, 50–54 and 54–58 (hex units).
- R3: The lookup hits chip i when start_i*8MB <= addr_i < end_i*8MB. Windows that are empty (end = start) or inverted (end < start) never match. The lowest matching index wins. offset_o is addr_i minus start_i*8MB. On a miss, hit_o, hit_idx_o and offset_o are all zero.
- R4: A write to chip 0 always stores BASE_U in the start field and keeps the written end field.
- R5: After the chip 0 correction, a write is dropped when end <= BASE_U or start > BASE_U + SPAN_U. A dropped write leaves the register unchanged and pulses rej_o.
- R6: An accepted write with end != start and with either end < start or start mod (end - start) != 0 pulses misal_o. The write is still stored.
- R7: An accepted write pulses ovl_o when, for some other chip j < NUM_CS, the new end > start_j and the new start < end_j. The write is still stored.
- R8: A write whose full 32-bit data equals the current register contents changes nothing and raises no flag.
- R9: Flags are one-cycle pulses, in the cycle after the write strobe. rej_o never appears together with misal_o or ovl_o. A write at an index of NUM_CS or above is ignored and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 3 | Chip select index written |
| wr_data_i | input | 32 | Write data |
| rd_idx_i | input | 3 | Chip select index read |
| rd_data_o | output | 32 | Read data |
| addr_i | input | 32 | Address to look up |
| hit_o | output | 1 | Address falls in a window |
| hit_idx_o | output | 3 | Matching chip select index |
| offset_o | output | 32 | Address offset within the window |
| rej_o | output | 1 | Write dropped (outside the aperture) |
| misal_o | output | 1 | Misaligned window written |
| ovl_o | output | 1 | Overlapping window written |

## Verification
The bench targets several corner cases:
- The start field sitting exactly at the aperture limit. A design with an off-by-one in the range test would drop a legal write or accept an illegal one.
- A write to chip 0 that only moves the start field. After correction this write matches the stored value, so it must still pass the checks and stay flag-free. A design that compares after correction, or that honours the new start, would diverge here.
- Empty windows, inverted windows and overlapping windows on the lookup side. A decoder that does not skip empty windows, or that prefers the highest index, returns the wrong chip.
- Writes whose value equals the register, and writes to indices that do not exist. A design that reacts to either would pulse a flag the bench does not expect.

A long run of random writes and lookups then compares every output against a behavioural model on every clock.

// File: rtl/fseg_pkg.sv
package fseg_pkg;
  localparam int MAX_CS  = 5;
  localparam int IDX_W   = 3;
  localparam int UNIT_SH = 23;

  typedef struct packed {
    logic [7:0] end_u;
    logic [7:0] start_u;
  } seg_t;

  function automatic logic [31:0] seg_pack(seg_t s);
    return {s.end_u, s.start_u, 16'h0000};
  endfunction
endpackage

// File: rtl/fseg_wr_check.sv
module fseg_wr_check
  import fseg_pkg::*;
#(
  parameter int         NUM_CS = 5,
  parameter logic [7:0] BASE_U = 8'h40,
  parameter logic [7:0] SPAN_U = 8'h20
) (
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [31:0]            wr_data_i,
  input  seg_t [NUM_CS-1:0]      segs_i,
  output seg_t                   new_seg_o,
  output logic [NUM_CS-1:0]      apply_o,
  output logic                   drop_o,
  output logic                   misal_o,
  output logic                   ovl_o
);
  localparam logic [8:0] LIM_U = {1'b0, BASE_U} + {1'b0, SPAN_U};

  logic       idx_ok, same, act, drop, misal, ovl;
  logic [7:0] s_fix, e_new, size_u, size_nz;
  seg_t       cur;

  always_comb begin
    idx_ok = 1'b0;
    cur    = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (wr_idx_i == IDX_W'(i)) begin
        idx_ok = 1'b1;
        cur    = segs_i[i];
      end
    end
  end

  assign same    = (wr_data_i == seg_pack(cur));
  assign act     = wr_en_i && idx_ok && !same;
  assign e_new   = wr_data_i[31:24];
  // chip 0 start is pinned to the aperture base
  assign s_fix   = (wr_idx_i == '0) ? BASE_U : wr_data_i[23:16];
  assign size_u  = e_new - s_fix;
  assign size_nz = (size_u == 8'd0) ? 8'd1 : size_u;

  assign drop  = (e_new <= BASE_U) || ({1'b0, s_fix} > LIM_U);
  assign misal = (e_new != s_fix) && ((e_new < s_fix) || ((s_fix % size_nz) != 8'd0));

  always_comb begin
    ovl = 1'b0;
    for (int j = 0; j < NUM_CS; j++) begin
      if (wr_idx_i != IDX_W'(j) &&
          e_new > segs_i[j].start_u && s_fix < segs_i[j].end_u)
        ovl = 1'b1;
    end
  end

  always_comb begin
    apply_o = '0;
    for (int i = 0; i < NUM_CS; i++)
      apply_o[i] = act && !drop && (wr_idx_i == IDX_W'(i));
  end

  assign new_seg_o = '{end_u: e_new, start_u: s_fix};
  assign drop_o    = act && drop;
  assign misal_o   = act && !drop && misal;
  assign ovl_o     = act && !drop && ovl;
endmodule

// File: rtl/fseg_lookup.sv
module fseg_lookup
  import fseg_pkg::*;
#(
  parameter int NUM_CS = 5
) (
  input  logic [31:0]        addr_i,
  input  seg_t [NUM_CS-1:0]  segs_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [31:0]        offset_o
);
  logic [8:0] unit;
  assign unit = addr_i[31:UNIT_SH];

  always_comb begin
    hit_o    = 1'b0;
    idx_o    = '0;
    offset_o = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (!hit_o && unit >= {1'b0, segs_i[i].start_u} &&
          unit < {1'b0, segs_i[i].end_u}) begin
        hit_o    = 1'b1;
        idx_o    = IDX_W'(i);
        offset_o = addr_i - {1'b0, segs_i[i].start_u, 23'd0};
      end
    end
  end
endmodule

// File: rtl/flash_seg_decoder.sv
module flash_seg_decoder
  import fseg_pkg::*;
#(
  parameter int                      NUM_CS    = 5,
  parameter logic [7:0]              BASE_U    = 8'h40,
  parameter logic [7:0]              SPAN_U    = 8'h20,
  parameter logic [8*MAX_CS-1:0]     DEF_START = 40'h54_50_4C_48_40,
  parameter logic [8*MAX_CS-1:0]     DEF_END   = 40'h58_54_50_4C_48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [31:0]       wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [31:0]       rd_data_o,
  input  logic [31:0]       addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [31:0]       offset_o,
  output logic              rej_o,
  output logic              misal_o,
  output logic              ovl_o
);
  localparam logic [IDX_W-1:0] NCS_L = IDX_W'(NUM_CS);

  seg_t [NUM_CS-1:0] seg_q;
  seg_t              new_seg;
  logic [NUM_CS-1:0] apply;
  logic              drop_c, misal_c, ovl_c;

  fseg_wr_check #(.NUM_CS(NUM_CS), .BASE_U(BASE_U), .SPAN_U(SPAN_U)) u_chk (
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_data_i(wr_data_i),
    .segs_i   (seg_q),
    .new_seg_o(new_seg),
    .apply_o  (apply),
    .drop_o   (drop_c),
    .misal_o  (misal_c),
    .ovl_o    (ovl_c)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seg_q[g] <= '{end_u: DEF_END[8*g +: 8], start_u: DEF_START[8*g +: 8]};
      end else if (apply[g]) begin
        seg_q[g] <= new_seg;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rej_o   <= 1'b0;
      misal_o <= 1'b0;
      ovl_o   <= 1'b0;
    end else begin
      rej_o   <= drop_c;
      misal_o <= misal_c;
      ovl_o   <= ovl_c;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (rd_idx_i == IDX_W'(i)) rd_data_o = seg_pack(seg_q[i]);
  end

  fseg_lookup #(.NUM_CS(NUM_CS)) u_lkp (
    .addr_i  (addr_i),
    .segs_i  (seg_q),
    .hit_o   (hit_o),
    .idx_o   (hit_idx_o),
    .offset_o(offset_o)
  );

  // R1
  low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[15:0] == 16'h0000);
  // R4
  cs0_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_q[0].start_u == BASE_U);
  // R3
  hit_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> hit_idx_o < NCS_L);
  // R9
  rej_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_o |-> !misal_o && !ovl_o);
  // R9
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rej_o || misal_o || ovl_o) |-> $past(wr_en_i));
  // R5
  drop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_c |=> $stable(seg_q));
endmodule

// File: tb/flash_seg_decoder_tb_top.sv
module flash_seg_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0, rd_idx = '0, hit_idx;
  logic [31:0] wr_data = '0, addr = '0, rd_data, offset;
  logic        hit, rej, misal, ovl;

  int n_chk = 0, n_bad = 0;
  int ms[5], me[5];
  bit exp_rej, exp_mis, exp_ovl;

  always #5 clk = ~clk;

  flash_seg_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .addr_i(addr), .hit_o(hit), .hit_idx_o(hit_idx), .offset_o(offset),
    .rej_o(rej), .misal_o(misal), .ovl_o(ovl)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mreg(int i);
    if (i >= 5) return 32'h0;
    return (32'(me[i]) << 24) | (32'(ms[i]) << 16);
  endfunction

  task automatic compare();
    int u, hi;
    logic [31:0] eo;
    chk(rd_data === mreg(rd_idx), "R1 read", rd_data, mreg(rd_idx));
    u = int'(addr >> 23);
    hi = -1;
    for (int i = 4; i >= 0; i--)
      if (ms[i] < me[i] && u >= ms[i] && u < me[i]) hi = i;
    eo = (hi >= 0) ? addr - (32'(ms[hi]) << 23) : 32'h0;
    chk(hit === (hi >= 0), "R3 hit", 32'(hit), 32'(hi >= 0));
    chk(hit_idx === ((hi >= 0) ? 3'(hi) : 3'd0), "R3 idx", 32'(hit_idx), 32'(hi));
    chk(offset === eo, "R3 offset", offset, eo);
    chk(rej === exp_rej, "R5 rej", 32'(rej), 32'(exp_rej));
    chk(misal === exp_mis, "R6 misal", 32'(misal), 32'(exp_mis));
    chk(ovl === exp_ovl, "R7 ovl", 32'(ovl), 32'(exp_ovl));
  endtask

  task automatic model_wr(bit we, int idx, logic [31:0] d);
    int s, e;
    exp_rej = 0; exp_mis = 0; exp_ovl = 0;
    if (!we || idx >= 5) return;   // R9 ignore
    if (d == mreg(idx)) return;    // R8
    e = int'(d[31:24]);
    s = (idx == 0) ? 'h40 : int'(d[23:16]);  // R4
    if (e <= 'h40 || s > 'h60) begin exp_rej = 1; return; end
    exp_mis = (e != s) && (e < s || (s % (e - s)) != 0);
    for (int j = 0; j < 5; j++)
      if (j != idx && e > ms[j] && s < me[j]) exp_ovl = 1;
    ms[idx] = s; me[idx] = e;
  endtask

  task automatic step(bit we, int idx, logic [31:0] d, int ri, logic [31:0] a);
    @(negedge clk);
    wr_en = we; wr_idx = 3'(idx); wr_data = d; rd_idx = 3'(ri); addr = a;
    #1 compare();
    @(posedge clk);
    model_wr(we, idx, d);
  endtask

  function automatic logic [31:0] seg(int e, int s);
    return (32'(e) << 24) | (32'(s) << 16);
  endfunction

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    ms = '{'h40, 'h48, 'h4C, 'h50, 'h54};
    me = '{'h48, 'h4C, 'h50, 'h54, 'h58};
    exp_rej = 0; exp_mis = 0; exp_ovl = 0;
    #12;
    chk(rd_data === 32'h48400000, "R2 reset cs0", rd_data, 32'h48400000);
    @(negedge clk); rst_n = 1'b1;
    // R2 defaults, R3 lookups
    step(0, 0, 0, 0, 32'h2000_0000);
    step(0, 0, 0, 1, 32'h23FF_FFFF);
    step(0, 0, 0, 2, 32'h2400_0000);
    step(0, 0, 0, 3, 32'h2B00_0000);
    step(0, 0, 0, 4, 32'h2C00_0000);
    step(0, 0, 0, 5, 32'h1000_0000);
    // R4: chip 0 start move is corrected
    step(1, 0, seg('h48, 'h30), 0, 32'h2000_0004);
    step(1, 0, seg('h44, 'h10), 0, 32'h2200_0000);
    // R8: equal write
    step(1, 1, 32'h4C48_0000, 1, 32'h2500_0000);
    // R5: drops and the limit
    step(1, 2, seg('h30, 'h28), 2, 32'h0);
    step(1, 3, seg('h70, 'h61), 3, 32'h0);
    step(1, 3, seg('h70, 'h60), 3, 32'h3000_0000);
    step(1, 2, seg('h40, 'h38), 2, 32'h0);
    // R6 misaligned, R7 overlap
    step(1, 2, seg('h5C, 'h56), 2, 32'h2B80_0000);
    step(1, 4, seg('h41, 'h00), 4, 32'h0080_0000);
    step(1, 1, seg('h44, 'h50), 1, 32'h2800_0000);
    // R3 empty window, priority
    step(1, 3, seg('h5A, 'h5A), 3, 32'h2D00_0000);
    step(1, 1, seg('h48, 'h40), 1, 32'h2100_0000);
    step(0, 0, 0, 1, 32'h2080_0000);
    // R9 / R1: nonexistent indices
    step(1, 5, seg('h50, 'h48), 5, 32'h0);
    step(1, 7, seg('h50, 'h48), 7, 32'h0);
    step(1, 2, 32'h5048_1234, 2, 32'h2400_0000);
    step(1, 2, 32'h5048_0000, 2, 32'h2400_0000);
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] d, a;
      d = {8'(8'h38 + $urandom % 48), 8'(8'h38 + $urandom % 48),
           (($urandom % 8) == 0) ? 16'($urandom) : 16'h0};
      a = {9'(9'h38 + $urandom % 48), 23'($urandom)};
      step(($urandom % 2) == 1, int'($urandom % 8), d, int'($urandom % 8), a);
    end
    step(0, 0, 0, 0, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule